// File: doc/BRIEF.md
# Dataflow Token-Matching Processing Element

This block is a single processing element of a static dataflow machine. It has no program counter. Work is carried by operand tokens, each holding a value, a target node number and an input port. A token enters the enabling stage, one per clock cycle, and is parked in the operand slots of its target node. When the node holds every operand it needs, it fires. Its slots are emptied, and its operands are joined with its opcode and destination list into an executable packet. The packet goes to a functional unit.

The functional unit's result is tagged with each destination node/port listed for the firing node. These new tokens go back through a small FIFO to the enabling stage, where they can complete other nodes. Execution order therefore comes only from which operands have arrived, never from an instruction sequence. The node table is written through a configuration port while the element is idle. New work is injected from outside as tokens. Tokens waiting in the FIFO take precedence over injected tokens. A node whose opcode is "output" turns its operand into a one-cycle result pulse on the output port.

The opcode set covers add, subtract, multiply, unsigned greater-than, and two steering gates. With these, a loop such as an iterative factorial can be written as a graph of up to 16 nodes.

Top module: `tokflow_pe`

## Requirements
- R1: After reset, `inj_ready` is 1, `done` is 1, `out_valid` is 0, and no node holds a stored operand.
- R2: A write with `cfg_we`=1 stores `cfg_entry` for node `cfg_node`. The field layout for the default 16-bit values and 16 nodes is: [2:0] opcode (0 add, 1 subtract, 2 multiply, 3 unsigned greater-than, 4 steer-true, 5 steer-false, 6 output), [3] two-operand flag, [4] destination-0 enable, [8:5] destination-0 node, [9] destination-0 port, [10] destination-1 enable, [14:11] destination-1 node, [15] destination-1 port, [31:16] immediate.
- R3: A one-operand node fires as soon as a token arrives for it. Its operand a is the token value and its operand b is the node's immediate.
- R4: A two-operand node stores its first token and fires only when a token arrives for its other port. Operand a is the port-0 value and operand b is the port-1 value, whichever port arrives first. Stored operands alone do not make `done` low.
- R5: Firing removes the node's stored operands, so each token is used exactly once and the node can fire again with fresh tokens.
- R6: Add, subtract and multiply give a+b, a-b and a*b modulo 2^16. Greater-than gives 1 when a > b unsigned and 0 otherwise.
- R7: A result is sent as a new token to every enabled destination of the firing node. These tokens re-enter the enabling stage and may fire further nodes.
- R8: A steer-true node forwards operand a when operand b is non-zero, and a steer-false node forwards it when b is zero. Otherwise the data is dropped and no token is produced. Output nodes produce no token either.
- R9: An output node raises `out_valid` for exactly one cycle with `out_value` equal to its operand a. This happens after the second rising clock edge following acceptance of the token that fired it.
- R10: While the feedback FIFO holds any token, `inj_ready` is 0 and the FIFO head is taken instead. An injected token is held, not lost, until accepted.
- R11: `done` is 1 exactly when the FIFO is empty and no packet is in the functional unit. It is 0 in the cycle after a firing token is accepted.
- R12: Programmed as a loop graph, the element computes n! (modulo 2^16) from n injected as j and 1 injected as k, including n=0 and n=1, which give 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Node table write strobe |
| cfg_node | input | 4 | Node number written |
| cfg_entry | input | 32 | Node table entry (layout in R2) |
| inj_valid | input | 1 | External token offered |
| inj_ready | output | 1 | External token accepted this cycle when valid |
| inj_node | input | 4 | Target node of the external token |
| inj_port | input | 1 | Target port of the external token |
| inj_value | input | 16 | Value of the external token |
| out_valid | output | 1 | One-cycle result pulse from an output node |
| out_value | output | 16 | Result value |
| done | output | 1 | No token queued and no packet executing |

## Verification
Two things can contend in one cycle: a fed-back result token and an externally injected token, both wanting the single enabling slot. The bench starts a factorial loop with two injections and then offers a third, unrelated token straight away. At that point the first firing has already filled the FIFO. The bench counts the cycles in which the offered token was refused. It then judges that both results arrive with their expected values, which shows that the refused token was held rather than dropped and that the loop was not disturbed. A steer that drops its data in the same cycle as a FIFO pop is judged by the FIFO occupancy checks and by clean reuse of the steer node afterwards.

// File: rtl/tokflow_pkg.sv
package tokflow_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_GT  = 3'd3,
    OP_STT = 3'd4,
    OP_STF = 3'd5,
    OP_OUT = 3'd6
  } op_e;
endpackage

// File: rtl/tf_fifo.sv
module tf_fifo #(
  parameter int DEPTH = 8,
  parameter int TW    = 21
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push0,
  input  logic [TW-1:0]              data0,
  input  logic                       push1,
  input  logic [TW-1:0]              data1,
  input  logic                       pop,
  output logic [TW-1:0]              head,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     cnt
);
  localparam int AW = $clog2(DEPTH);

  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [1:0]    npush;
  logic [TW-1:0] first;

  assign npush = {1'b0, push0} + {1'b0, push1};
  assign first = push0 ? data0 : data1;
  assign head  = mem[rptr];
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (npush != 2'd0) mem[wptr] <= first;
    if (npush == 2'd2) mem[wptr + AW'(1)] <= data1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr + AW'(npush);
      if (pop && !empty) rptr <= rptr + AW'(1);
      cnt  <= cnt + (AW+1)'(npush) - (AW+1)'(pop && !empty);
    end
  end
endmodule

// File: rtl/tf_match.sv
module tf_match #(
  parameter int NODES = 16,
  parameter int DW    = 16,
  parameter int NW    = 4,
  parameter int EW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [NW-1:0]    cfg_node,
  input  logic [EW-1:0]    cfg_entry,
  input  logic             tok_v,
  input  logic [NW-1:0]    tok_node,
  input  logic             tok_port,
  input  logic [DW-1:0]    tok_val,
  output logic             fire,
  output logic [NW-1:0]    fire_node,
  output logic [NODES-1:0] slot_any,
  output logic             pkt_v,
  output logic [2:0]       pkt_op,
  output logic [DW-1:0]    pkt_a,
  output logic [DW-1:0]    pkt_b,
  output logic [2*(NW+2)-1:0] pkt_dst
);
  localparam int DSTW  = 2*(NW+2);
  localparam int P_TWO = 3;
  localparam int P_DST = 4;
  localparam int P_IMM = P_DST + DSTW;

  logic [EW-1:0] tbl [NODES];
  logic [1:0]    slot_v   [NODES];
  logic [DW-1:0] slot_val [NODES][2];

  logic [EW-1:0] ent;
  logic          two, partner;
  logic [DW-1:0] opa, opb;

  assign ent     = tbl[tok_node];
  assign two     = ent[P_TWO];
  assign partner = slot_v[tok_node][~tok_port];
  assign fire    = tok_v && (!two || partner);
  assign fire_node = tok_node;

  always_comb begin
    if (!two) begin
      opa = tok_val;
      opb = ent[P_IMM +: DW];
    end else begin
      opa = tok_port ? slot_val[tok_node][0] : tok_val;
      opb = tok_port ? tok_val : slot_val[tok_node][1];
    end
  end

  for (genvar g = 0; g < NODES; g++) begin : g_any
    assign slot_any[g] = |slot_v[g];
  end

  always_ff @(posedge clk) begin
    if (cfg_we) tbl[cfg_node] <= cfg_entry;
  end

  always_ff @(posedge clk) begin
    if (tok_v && !fire) slot_val[tok_node][tok_port] <= tok_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NODES; i++) slot_v[i] <= 2'b00;
      pkt_v <= 1'b0;
    end else begin
      pkt_v <= fire;
      if (fire)       slot_v[tok_node] <= 2'b00;
      else if (tok_v) slot_v[tok_node][tok_port] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      pkt_op  <= ent[2:0];
      pkt_a   <= opa;
      pkt_b   <= opb;
      pkt_dst <= ent[P_DST +: DSTW];
    end
  end
endmodule

// File: rtl/tf_fu.sv
module tf_fu #(
  parameter int DW = 16
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          makes_token
);
  import tokflow_pkg::*;

  function automatic logic [DW-1:0] alu_eval(input logic [2:0] o,
                                             input logic [DW-1:0] x,
                                             input logic [DW-1:0] y);
    case (o)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_MUL:  return x * y;
      OP_GT:   return (x > y) ? DW'(1) : DW'(0);
      default: return x;
    endcase
  endfunction

  function automatic logic gives_token(input logic [2:0] o,
                                       input logic [DW-1:0] ctl);
    case (o)
      OP_STT:  return (ctl != '0);
      OP_STF:  return (ctl == '0);
      OP_OUT:  return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  assign res         = alu_eval(op, a, b);
  assign makes_token = gives_token(op, b);
endmodule

// File: rtl/tokflow_pe.sv
module tokflow_pe #(
  parameter int NODES      = 16,
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int CFG_W      = 4 + 2*($clog2(NODES)+2) + DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NODES)-1:0]    cfg_node,
  input  logic [CFG_W-1:0]            cfg_entry,
  input  logic                        inj_valid,
  output logic                        inj_ready,
  input  logic [$clog2(NODES)-1:0]    inj_node,
  input  logic                        inj_port,
  input  logic [DW-1:0]               inj_value,
  output logic                        out_valid,
  output logic [DW-1:0]               out_value,
  output logic                        done
);
  import tokflow_pkg::*;

  localparam int NW   = $clog2(NODES);
  localparam int TW   = NW + 1 + DW;
  localparam int DSTW = 2*(NW+2);
  localparam int CW   = $clog2(FIFO_DEPTH) + 1;

  logic [TW-1:0]   fifo_head, tok0, tok1;
  logic            fifo_empty;
  logic [CW-1:0]   fifo_cnt;
  logic            push0, push1, fb_take;

  logic            tok_v, tok_port;
  logic [NW-1:0]   tok_node;
  logic [DW-1:0]   tok_val;

  logic            fire;
  logic [NW-1:0]   fire_node;
  logic [NODES-1:0] slot_any;
  logic            pkt_v;
  logic [2:0]      pkt_op;
  logic [DW-1:0]   pkt_a, pkt_b, fu_res;
  logic [DSTW-1:0] pkt_dst;
  logic            makes_token, emit;

  // enabling stage: queued feedback first, outside tokens only when queue is empty
  assign fb_take   = !fifo_empty;
  assign inj_ready = fifo_empty;
  assign tok_v     = fb_take || inj_valid;
  assign {tok_node, tok_port, tok_val} =
    fb_take ? fifo_head : {inj_node, inj_port, inj_value};

  tf_match #(.NODES(NODES), .DW(DW), .NW(NW), .EW(CFG_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_node(cfg_node), .cfg_entry(cfg_entry),
    .tok_v(tok_v), .tok_node(tok_node), .tok_port(tok_port), .tok_val(tok_val),
    .fire(fire), .fire_node(fire_node), .slot_any(slot_any),
    .pkt_v(pkt_v), .pkt_op(pkt_op), .pkt_a(pkt_a), .pkt_b(pkt_b), .pkt_dst(pkt_dst)
  );

  tf_fu #(.DW(DW)) u_fu (
    .op(pkt_op), .a(pkt_a), .b(pkt_b), .res(fu_res), .makes_token(makes_token)
  );

  // tag the result with each enabled destination
  assign emit  = pkt_v && makes_token;
  assign push0 = emit && pkt_dst[0];
  assign push1 = emit && pkt_dst[NW+2];
  assign tok0  = {pkt_dst[1 +: NW], pkt_dst[NW+1], fu_res};
  assign tok1  = {pkt_dst[NW+3 +: NW], pkt_dst[2*NW+3], fu_res};

  tf_fifo #(.DEPTH(FIFO_DEPTH), .TW(TW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push0(push0), .data0(tok0), .push1(push1), .data1(tok1),
    .pop(fb_take), .head(fifo_head), .empty(fifo_empty), .cnt(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= pkt_v && (pkt_op == OP_OUT);
      if (pkt_v && (pkt_op == OP_OUT)) out_value <= pkt_a;
    end
  end

  assign done = fifo_empty && !pkt_v;
endmodule

// File: rtl/tokflow_pe_chk.sv
module tokflow_pe_chk #(
  parameter int DEPTH = 8,
  parameter int NODES = 16,
  parameter int NW    = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [$clog2(DEPTH):0]    fifo_cnt,
  input logic                      fifo_empty,
  input logic                      pkt_v,
  input logic [2:0]                pkt_op,
  input logic                      makes_token,
  input logic                      out_valid,
  input logic                      done,
  input logic                      fire,
  input logic [NW-1:0]             fire_node,
  input logic [NODES-1:0]          slot_any
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH)); // R10

  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !slot_any[$past(fire_node)]); // R5

  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid); // R11

  AST_OUT_FROM_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pkt_v)); // R9

  AST_DROP_NO_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_v && !makes_token) |=>
      (fifo_cnt + CW'(!$past(fifo_empty)) == $past(fifo_cnt))); // R8
endmodule

bind tokflow_pe tokflow_pe_chk #(.DEPTH(FIFO_DEPTH), .NODES(NODES), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .fifo_empty(fifo_empty),
  .pkt_v(pkt_v), .pkt_op(pkt_op), .makes_token(makes_token),
  .out_valid(out_valid), .done(done), .fire(fire), .fire_node(fire_node),
  .slot_any(slot_any)
);

// File: tb/sim_tokflow_pe.sv
`timescale 1ns/1ps
module sim_tokflow_pe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_node = '0;
  logic [31:0] cfg_entry = '0;
  logic        inj_valid = 1'b0;
  logic        inj_ready;
  logic [3:0]  inj_node = '0;
  logic        inj_port = 1'b0;
  logic [15:0] inj_value = '0;
  logic        out_valid;
  logic [15:0] out_value;
  logic        done;

  int checks = 0, fails = 0, cycles = 0, stalls = 0;
  int out_n = 0;
  logic [15:0] outs [16];

  tokflow_pe u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_node(cfg_node),
    .cfg_entry(cfg_entry), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_node(inj_node), .inj_port(inj_port), .inj_value(inj_value),
    .out_valid(out_valid), .out_value(out_value), .done(done)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (out_valid) begin
      outs[out_n % 16] = out_value;
      out_n++;
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int two,
      input int e0, input int n0, input int p0,
      input int e1, input int n1, input int p1, input int imm);
    mk = {imm[15:0], p1[0], n1[3:0], e1[0], p0[0], n0[3:0], e0[0], two[0], op[2:0]};
  endfunction

  function automatic logic [15:0] fact(input int n);
    logic [15:0] k = 16'd1;
    for (int j = n; j > 1; j--) k = k * j[15:0];
    return k;
  endfunction

  task automatic wr(input int nd, input logic [31:0] e);
    @(negedge clk);
    cfg_we = 1'b1; cfg_node = nd[3:0]; cfg_entry = e;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic inject(input int nd, input int pt, input int v);
    @(negedge clk);
    inj_valid = 1'b1; inj_node = nd[3:0]; inj_port = pt[0]; inj_value = v[15:0];
    while (!inj_ready) begin stalls++; @(negedge clk); end
    @(posedge clk);
    #1 inj_valid = 1'b0;
  endtask

  task automatic wait_out(input int start, input int want);
    for (int i = 0; i < 4000 && out_n < start + want; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // R2: program the node table (factorial loop on nodes 0..10, test nodes 11..15)
  task automatic load_program();
    wr(0,  mk(0,0, 1,1,0, 1,2,0, 0));   // copy j
    wr(1,  mk(3,0, 1,2,1, 1,5,0, 1));   // j > 1
    wr(5,  mk(0,0, 1,3,1, 1,6,1, 0));   // copy control
    wr(2,  mk(4,1, 1,4,0, 0,0,0, 0));   // steer-true j
    wr(7,  mk(0,0, 1,3,0, 1,6,0, 0));   // copy k
    wr(3,  mk(4,1, 1,8,0, 0,0,0, 0));   // steer-true k
    wr(6,  mk(5,1, 1,9,0, 0,0,0, 0));   // steer-false k
    wr(4,  mk(0,0, 1,8,1, 1,10,0, 0));  // copy j into loop
    wr(8,  mk(2,1, 1,7,0, 0,0,0, 0));   // k*j
    wr(10, mk(1,0, 1,0,0, 0,0,0, 1));   // j-1
    wr(9,  mk(6,0, 0,0,0, 0,0,0, 0));   // output
    wr(11, mk(0,0, 1,12,0, 0,0,0, 100));
    wr(12, mk(6,0, 0,0,0, 0,0,0, 0));
    wr(13, mk(1,1, 1,12,0, 0,0,0, 0));
    wr(14, mk(5,1, 1,12,0, 0,0,0, 0));
    wr(15, mk(4,1, 1,12,0, 0,0,0, 0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(inj_ready == 1'b1, "R1 inj_ready after reset", inj_ready, 1);
    chk(done == 1'b1,      "R1 done after reset", done, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_latency();
    int s = out_n;
    @(negedge clk);
    inj_valid = 1'b1; inj_node = 4'd12; inj_port = 1'b0; inj_value = 16'h0055;
    @(negedge clk);
    inj_valid = 1'b0;
    chk(out_valid == 1'b0, "R9 no pulse after first edge", out_valid, 0);
    chk(done == 1'b0, "R11 done low with packet in flight", done, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 pulse after second edge", out_valid, 1);
    chk(out_value == 16'h0055, "R9 output value", out_value, 16'h55);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 pulse one cycle wide", out_valid, 0);
    chk(done == 1'b1, "R11 done back high", done, 1);
    chk(out_n == s + 1, "R9 single pulse count", out_n - s, 1);
  endtask

  task automatic t_single();
    int s = out_n;
    inject(11, 0, 23);
    wait_out(s, 1);
    chk(out_n == s + 1 && outs[s % 16] == 16'd123, "R3 one-operand add with immediate",
        outs[s % 16], 123);
    wait_idle();
  endtask

  task automatic t_pair();
    int s = out_n;
    inject(13, 1, 5);
    repeat (6) @(negedge clk);
    chk(out_n == s, "R4 waits for partner", out_n - s, 0);
    chk(done == 1'b1, "R4 stored operand leaves done high", done, 1);
    inject(13, 0, 20);
    wait_out(s, 1);
    chk(outs[s % 16] == 16'd15, "R4 port0 minus port1", outs[s % 16], 15);
    wait_idle();
    // R5: same node again with port0 first, wrap-around subtract (R6)
    s = out_n;
    inject(13, 0, 3);
    inject(13, 1, 7);
    wait_out(s, 1);
    chk(out_n == s + 1 && outs[s % 16] == 16'hFFFC, "R5 node refires with fresh tokens, R6 wrap",
        outs[s % 16], 16'hFFFC);
    wait_idle();
  endtask

  task automatic t_steer();
    int s = out_n;
    inject(14, 0, 7);
    inject(14, 1, 1);
    wait_idle();
    chk(out_n == s, "R8 steer-false drops on nonzero control", out_n - s, 0);
    inject(14, 1, 0);
    inject(14, 0, 9);
    wait_out(s, 1);
    chk(out_n == s + 1 && outs[s % 16] == 16'd9, "R8 steer-false passes on zero, R5 slots clean",
        outs[s % 16], 9);
    wait_idle();
    s = out_n;
    inject(15, 0, 4);
    inject(15, 1, 0);
    wait_idle();
    chk(out_n == s, "R8 steer-true drops on zero control", out_n - s, 0);
    inject(15, 0, 11);
    inject(15, 1, 2);
    wait_out(s, 1);
    chk(out_n == s + 1 && outs[s % 16] == 16'd11, "R8 steer-true passes", outs[s % 16], 11);
    wait_idle();
  endtask

  task automatic t_fact(input int n);
    int s = out_n;
    logic [15:0] e = fact(n);
    inject(0, 0, n);
    inject(7, 0, 1);
    wait_out(s, 1);
    wait_idle();
    chk(out_n == s + 1, "R12 one result per run", out_n - s, 1);
    chk(outs[s % 16] == e, "R12 R6 R7 factorial value", outs[s % 16], e);
  endtask

  task automatic t_priority();
    int s = out_n;
    stalls = 0;
    inject(0, 0, 4);
    inject(7, 0, 1);
    inject(11, 0, 1);
    wait_out(s, 2);
    wait_idle();
    chk(stalls > 0, "R10 injection held back while feedback queued", stalls, 1);
    chk(out_n == s + 2, "R10 both results delivered", out_n - s, 2);
    chk((outs[s % 16] == 16'd24 && outs[(s+1) % 16] == 16'd101) ||
        (outs[s % 16] == 16'd101 && outs[(s+1) % 16] == 16'd24),
        "R10 held token not lost, loop undisturbed", outs[s % 16], 24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    load_program();
    t_latency();
    t_single();
    t_pair();
    t_steer();
    t_fact(0);
    t_fact(1);
    t_fact(3);
    t_fact(5);
    t_fact(8);
    t_fact(9);   // R6 multiply wraps modulo 2^16
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule